// File: doc/BRIEF.md
# Pipeline Trap Commit Unit

This block handles exceptions and interrupts for an in-order pipeline with fetch, decode, execute, memory and writeback stages. A pending fault does not act in the stage where it is raised. A cause code and the instruction's PC go with the instruction into the decode, execute and memory stage registers. The block acts on the code only when the instruction reaches the commit point in the memory stage. A fault from an earlier stage stays attached to the instruction, so faults that a later stage reports for the same instruction are dropped.

At commit the block first checks for an external interrupt request. An interrupt beats every fault that the committing instruction carries. When a trap is taken, the block does four things. It records a cause code and the committing instruction's PC. It kills the fetch, decode and execute stages. It blocks the committing instruction's writeback. It steers fetch to a fixed handler address. For an interrupt, the committing instruction is itself discarded, so it runs again after the handler returns. The pipeline moves forward one stage every clock. The surrounding datapath supplies one fault strobe for each stage, and each strobe describes the instruction that is in that stage during that cycle.

Top module: `trap_commit`

## Requirements
- R1: After reset the cause output is 0, the saved PC is 0, and no kill or redirect output is asserted.
- R2: An instruction presented at fetch in cycle t reaches commit in cycle t+3. Its trap, if any, shows on the kill and redirect outputs in cycle t+3 and in no earlier cycle.
- R3: Among the faults of one instruction, the one raised in the earliest stage decides the cause. Faults from later stages are not recorded for that instruction.
- R4: An interrupt request is taken only while a valid instruction is at commit. It then overrides any fault that instruction carries.
- R5: Cause encoding is 0 none, 1 interrupt, 2 fetch address fault, 3 illegal opcode, 4 arithmetic overflow, 5 data address fault.
- R6: At the clock edge that ends a trap cycle, the cause output and the saved PC take the trap's cause and the committing instruction's PC. Both hold their values in all other cycles.
- R7: In a trap cycle the fetch, decode, execute and writeback kill outputs are all asserted. The instructions that were in fetch, decode and execute are discarded and never trap.
- R8: In a trap cycle the redirect output is asserted with the handler address, which is a parameter. Outside a trap cycle the redirect address reads 0.
- R9: An instruction that reaches commit with no fault, and with no interrupt pending, raises no redirect and no kill and leaves the cause unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A valid instruction is in fetch this cycle |
| fetchPc | input | PC_W | PC of the instruction in fetch |
| fetchFault | input | 1 | Fetch address fault for the instruction in fetch |
| decIllegal | input | 1 | Illegal opcode for the instruction in decode |
| exeOverflow | input | 1 | Arithmetic overflow for the instruction in execute |
| memAddrFault | input | 1 | Data address fault for the instruction in memory |
| irq | input | 1 | External interrupt request |
| killFetch | output | 1 | Discard the fetch stage |
| killDecode | output | 1 | Discard the decode stage |
| killExecute | output | 1 | Discard the execute stage |
| killWb | output | 1 | Suppress writeback of the committing instruction |
| redirect | output | 1 | Steer fetch to the handler |
| redirectPc | output | PC_W | Handler address while redirecting, 0 otherwise |
| causeOut | output | 3 | Recorded trap cause |
| epcOut | output | PC_W | Recorded PC of the trapping instruction |

## Verification
The kill and redirect outputs are combinational on the memory-stage register. They are due in the third cycle after the fetch cycle. The bench drives the fault strobes just after falling edges and reads these outputs 1 ns later, in that same cycle. The cause and saved PC are registered, so they change one edge later. The bench reads them after the next falling edge and sweeps all 32 combinations of the four fault sources and the interrupt. Separate sequences cover an older instruction against a younger one, a flush of younger instructions, and an interrupt raised while no instruction is at commit.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_IRQ      = 3'd1,
    CAUSE_FETCH    = 3'd2,
    CAUSE_ILLEGAL  = 3'd3,
    CAUSE_OVERFLOW = 3'd4,
    CAUSE_DATA     = 3'd5
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic capture;
    logic takeIrq;
  } strobe_t;
endpackage

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         ctl,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            fetchFault,
  input  logic [2:0]      stageFault,   // [0] decode, [1] execute, [2] memory
  output logic            memValid,
  output logic [PC_W-1:0] memPc,
  output cause_e          memCause,
  output cause_e          causeReg,
  output logic [PC_W-1:0] epcReg
);
  localparam int STAGES = 3;
  localparam int LAST   = STAGES - 1;

  logic [STAGES-1:0] stValid;
  logic [PC_W-1:0]   stPc     [STAGES];
  cause_e            stCause  [STAGES];
  cause_e            effCause [STAGES];

  // a carried cause always wins over a fault raised here
  always_comb begin
    for (int s = 0; s < STAGES; s++) begin
      if (stCause[s] != CAUSE_NONE)
        effCause[s] = stCause[s];
      else if (stageFault[s])
        effCause[s] = cause_e'(3'(int'(CAUSE_ILLEGAL) + s));
      else
        effCause[s] = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid <= '0;
      for (int s = 0; s < STAGES; s++) begin
        stPc[s]    <= '0;
        stCause[s] <= CAUSE_NONE;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        if (s == 0) begin
          stValid[s] <= fetchValid && !ctl.flush;
          stPc[s]    <= fetchPc;
          stCause[s] <= fetchFault ? CAUSE_FETCH : CAUSE_NONE;
        end else begin
          stValid[s] <= stValid[s-1] && !ctl.flush;
          stPc[s]    <= stPc[s-1];
          stCause[s] <= effCause[s-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg <= CAUSE_NONE;
      epcReg   <= '0;
    end else if (ctl.capture) begin
      causeReg <= ctl.takeIrq ? CAUSE_IRQ : effCause[LAST];
      epcReg   <= stPc[LAST];
    end
  end

  assign memValid = stValid[LAST];
  assign memPc    = stPc[LAST];
  assign memCause = effCause[LAST];
endmodule

// File: rtl/trap_control.sv
module trap_control
  import trap_pkg::*;
(
  input  logic    memValid,
  input  cause_e  memCause,
  input  logic    irq,
  output strobe_t ctl,
  output logic    trap
);
  always_comb begin
    trap        = memValid && (irq || memCause != CAUSE_NONE);
    ctl.flush   = trap;
    ctl.capture = trap;
    ctl.takeIrq = irq;
  end
endmodule

// File: rtl/trap_commit.sv
module trap_commit
  import trap_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            fetchFault,
  input  logic            decIllegal,
  input  logic            exeOverflow,
  input  logic            memAddrFault,
  input  logic            irq,
  output logic            killFetch,
  output logic            killDecode,
  output logic            killExecute,
  output logic            killWb,
  output logic            redirect,
  output logic [PC_W-1:0] redirectPc,
  output logic [2:0]      causeOut,
  output logic [PC_W-1:0] epcOut
);
  strobe_t         ctl;
  logic            trap;
  logic            memValid;
  logic [PC_W-1:0] memPc;
  cause_e          memCause;
  cause_e          causeReg;

  trap_datapath #(.PC_W(PC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc),
    .fetchFault (fetchFault),
    .stageFault ({memAddrFault, exeOverflow, decIllegal}),
    .memValid   (memValid),
    .memPc      (memPc),
    .memCause   (memCause),
    .causeReg   (causeReg),
    .epcReg     (epcOut)
  );

  trap_control u_ctl (
    .memValid (memValid),
    .memCause (memCause),
    .irq      (irq),
    .ctl      (ctl),
    .trap     (trap)
  );

  assign killFetch   = trap;
  assign killDecode  = trap;
  assign killExecute = trap;
  assign killWb      = trap;
  assign redirect    = trap;
  assign redirectPc  = trap ? HANDLER_PC : '0;
  assign causeOut    = causeReg;
endmodule

// File: rtl/trap_commit_chk.sv
module trap_commit_chk #(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input logic            clk,
  input logic            rstN,
  input logic            irq,
  input logic            killFetch,
  input logic            killDecode,
  input logic            killExecute,
  input logic            killWb,
  input logic            redirect,
  input logic [PC_W-1:0] redirectPc,
  input logic [2:0]      causeOut,
  input logic [PC_W-1:0] epcOut
);
  // R7
  no_back2back_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);
  // R7
  kill_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (killFetch && killDecode && killExecute && killWb));
  // R6
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !redirect |=> ($stable(causeOut) && $stable(epcOut)));
  // R5
  cause_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (causeOut != 3'd0 && causeOut <= 3'd5));
  // R4
  irq_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && irq) |=> (causeOut == 3'd1));
  // R8
  handler_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (redirectPc == HANDLER_PC));
endmodule

bind trap_commit trap_commit_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq),
  .killFetch(killFetch), .killDecode(killDecode), .killExecute(killExecute),
  .killWb(killWb), .redirect(redirect), .redirectPc(redirectPc),
  .causeOut(causeOut), .epcOut(epcOut)
);

// File: tb/trap_commit_test.sv
`timescale 1ns/1ps
module trap_commit_test;
  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 1'b0, fetchFault = 1'b0, decIllegal = 1'b0;
  logic exeOverflow = 1'b0, memAddrFault = 1'b0, irq = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic killFetch, killDecode, killExecute, killWb, redirect;
  logic [PC_W-1:0] redirectPc, epcOut;
  logic [2:0] causeOut;

  int tests = 0;
  int fails = 0;
  logic [2:0]  expCause = 3'd0;
  logic [31:0] expEpc = '0;

  always #5 clk = ~clk;

  trap_commit #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    fetchValid = 0; fetchFault = 0; decIllegal = 0;
    exeOverflow = 0; memAddrFault = 0; irq = 0;
  endtask

  task automatic noTrap(input string req);
    chk(req, {27'd0, killFetch, killDecode, killExecute, killWb, redirect}, 32'd0);
    chk(req, redirectPc, 32'd0);
  endtask

  task automatic allKill(input string req);
    chk(req, {27'd0, killFetch, killDecode, killExecute, killWb, redirect}, 32'h1f);
    chk(req, redirectPc, HANDLER);
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 cause", {29'd0, causeOut}, 32'd0);
    chk("R1 epc", epcOut, 32'd0);
    noTrap("R1 outputs");
    @(negedge clk); rstN = 1;

    // R2 R3 R4 R5 R6 R9: sweep all fault/interrupt combinations
    for (int m = 0; m < 32; m++) begin
      logic [31:0] pc;
      logic [2:0] c;
      pc = 32'h1000 + 32'(m) * 4;
      c = m[4] ? 3'd1 : m[0] ? 3'd2 : m[1] ? 3'd3 : m[2] ? 3'd4 : m[3] ? 3'd5 : 3'd0;
      @(negedge clk); clearIn(); fetchValid = 1; fetchPc = pc; fetchFault = m[0];
      #1 noTrap("R2 fetch cycle");
      @(negedge clk); clearIn(); decIllegal = m[1];
      #1 noTrap("R2 decode cycle");
      @(negedge clk); clearIn(); exeOverflow = m[2];
      #1 noTrap("R2 execute cycle");
      @(negedge clk); clearIn(); memAddrFault = m[3]; irq = m[4];
      #1;
      if (c != 0) allKill("R2 R7 R8 commit trap");
      else noTrap("R9 clean commit");
      @(negedge clk); clearIn();
      if (c != 0) begin expCause = c; expEpc = pc; end
      #1;
      chk("R3 R4 R5 R6 cause", {29'd0, causeOut}, {29'd0, expCause});
      chk("R6 epc", epcOut, expEpc);
    end

    // R7 R3: older overflow beats younger illegal; younger ones flushed
    @(negedge clk); clearIn(); fetchValid = 1; fetchPc = 32'h2000;
    @(negedge clk); clearIn(); fetchValid = 1; fetchPc = 32'h2004;
    @(negedge clk); clearIn(); fetchValid = 1; fetchPc = 32'h2008;
    exeOverflow = 1; decIllegal = 1;
    @(negedge clk); clearIn(); fetchValid = 1; fetchPc = 32'h200c; fetchFault = 1;
    #1 allKill("R7 older commit trap");
    @(negedge clk); clearIn(); irq = 1;
    #1 chk("R3 older cause", {29'd0, causeOut}, 32'd4);
    chk("R6 older epc", epcOut, 32'h2000);
    noTrap("R7 younger flushed c1");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); clearIn(); irq = 1; memAddrFault = 1; exeOverflow = 1;
      #1 noTrap("R7 younger flushed");
    end
    @(negedge clk); clearIn();
    #1 chk("R4 R7 cause kept", {29'd0, causeOut}, 32'd4);
    chk("R4 R7 epc kept", epcOut, 32'h2000);

    // R4: interrupt arriving after a clean commit waits for the next instruction
    @(negedge clk); clearIn(); fetchValid = 1; fetchPc = 32'h3000;
    @(negedge clk); clearIn(); fetchValid = 1; fetchPc = 32'h3004;
    @(negedge clk); clearIn();
    @(negedge clk); clearIn();
    #1 noTrap("R9 first clean");
    @(negedge clk); clearIn(); irq = 1;
    #1 allKill("R4 irq on second");
    @(negedge clk); clearIn();
    #1 chk("R4 irq cause", {29'd0, causeOut}, 32'd1);
    chk("R4 irq epc", epcOut, 32'h3004);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule